// File: doc/BRIEF.md
# March-Test Memory Self-Test Controller

This block wraps a single-port synchronous RAM. It can take over the RAM's address, write-data and write-enable lines and run a march test on its own. In functional mode the RAM is driven straight from the surrounding logic. When test mode is set and start is pulsed, a sequencer walks the array. It applies one read or write operation per clock, and within each march element it completes the element's operation list at one address before it moves to the next address.

Two programs are available. The first is a six-operation-per-word march: write zero, then read-zero/write-one ascending, then read-one/write-zero/read-zero descending. The second is the ten-operation March C- program. Either program runs once for each data background of a word-oriented memory, and the number of backgrounds is log2 of the word width plus one. Each read is compared with the expected word one cycle later, because the RAM returns read data one cycle after the address is presented. A sticky fail flag records any mismatch, together with the address and background index of the first mismatch. A done flag marks the end of the run.

The controller has three states. IDLE goes to RUN on an accepted start. RUN goes to DRAIN after the last operation of the last background. DRAIN goes back to IDLE after one cycle, and in that cycle the last read is compared and done is raised.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, busy, done and fail are 0, fail_addr and fail_bg are 0, and the RAM lines follow the functional inputs.
- R2: While test_mode is 0, ram_addr, ram_wdata and ram_we equal func_addr, func_wdata and func_we, and start has no effect (busy stays 0).
- R3: With test_mode at 1 and the controller in IDLE, a start sampled at a clock edge puts the first operation on the RAM lines in the next cycle. From then until done, busy is 1, and further start pulses have no effect on the operation sequence.
- R4: With alg_sel=0, each background applies: W0 at every address ascending; then at each address ascending R0, W1; then at each address descending R1, W0, R0.
- R5: With alg_sel=1, each background applies these elements in order: W0 ascending; R0,W1 ascending; R1,W0 ascending; R0,W1 descending; R1,W0 descending; R0 ascending.
- R6: Backgrounds run in index order 0 to NBG-1, with NBG = log2(DW)+1. Background 0 is all zeros. For index k≥1, bit i of the word is 1 when i modulo 2·(DW>>k) is below DW>>k (00001111, 00110011, 01010101 for DW=8). A logical 1 writes or expects the bitwise complement of the background.
- R7: Ascending elements run from address 0 to the top address, descending elements run from the top address to 0, and the address never wraps inside an element.
- R8: A read issued in cycle t is compared with ram_rdata in cycle t+1. On a mismatch, fail reads 1 from cycle t+2 on.
- R9: fail is sticky until the next accepted start, which clears it.
- R10: fail_addr and fail_bg hold the address and background index of the first mismatching read of the run. Later mismatches do not change them.
- R11: The cycle after the last operation is a drain cycle with busy=1 and ram_we=0. From the following cycle, busy is 0 and done is 1 until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | 1 routes RAM lines from the sequencer |
| start | input | 1 | Starts a run when idle in test mode |
| alg_sel | input | 1 | 0: six-op march, 1: March C- |
| func_addr | input | AW | Functional address |
| func_wdata | input | DW | Functional write data |
| func_we | input | 1 | Functional write enable |
| ram_rdata | input | DW | RAM read data, one cycle after address |
| ram_addr | output | AW | Address to RAM |
| ram_wdata | output | DW | Write data to RAM |
| ram_we | output | 1 | Write enable to RAM |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of first mismatch |
| fail_bg | output | BGW | Background index of first mismatch |

## Verification
The hardest case to reach from the ports is a defect that stays hidden in every background but the last. Such a defect checks whether the background words and the recorded background index are correct. The bench's RAM model can short bit 0 of one word to bit 1 as a wired AND. Only the alternating background stores different values in those two bits, so a correct controller first reports that word at background 3. A stuck bit that fails many times across the run exercises first-failure retention. The bench's behavioural model runs the same faulty memory and predicts, cycle by cycle, the cycle in which fail must rise.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } mb_state_e;

    typedef struct packed {
        logic rd;   // 1: read-and-compare, 0: write
        logic val;  // logical data value (0: background, 1: complement)
    } mb_op_t;

    // number of march elements in the selected program
    function automatic logic [2:0] prog_elems(input logic alg);
        return alg ? 3'd6 : 3'd3;
    endfunction

    // address direction of an element: 1 = descending
    function automatic logic elem_is_down(input logic alg, input logic [2:0] e);
        if (alg) return (e == 3'd3) || (e == 3'd4);
        return e == 3'd2;
    endfunction

    // operations per address in an element
    function automatic logic [1:0] elem_ops(input logic alg, input logic [2:0] e);
        if (alg) return ((e == 3'd0) || (e == 3'd5)) ? 2'd1 : 2'd2;
        case (e)
            3'd0:    return 2'd1;
            3'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic mb_op_t elem_op(input logic alg, input logic [2:0] e,
                                       input logic [1:0] o);
        mb_op_t r;
        r.rd  = 1'b0;
        r.val = 1'b0;
        if (!alg) begin
            case (e)
                3'd1: begin r.rd = (o == 2'd0); r.val = (o != 2'd0); end
                3'd2: begin r.rd = (o != 2'd1); r.val = (o == 2'd0); end
                default: ;
            endcase
        end else begin
            case (e)
                3'd1, 3'd3: begin r.rd = (o == 2'd0); r.val = (o != 2'd0); end
                3'd2, 3'd4: begin r.rd = (o == 2'd0); r.val = (o == 2'd0); end
                3'd5:       begin r.rd = 1'b1; end
                default: ;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mbist_addr.sv
module mbist_addr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_down,
    input  logic          step,
    input  logic          cur_down,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    localparam logic [AW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr <= '0;
        else if (load)  addr <= load_down ? TOP : '0;
        else if (step)  addr <= cur_down ? addr - 1'b1 : addr + 1'b1;
    end

    assign at_end = cur_down ? (addr == '0) : (addr == TOP);

    // stepping is only requested before the last address of an element
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_end);

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int AW  = 4,
    parameter int DW  = 8,
    parameter int BGW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           chk_en,
    input  logic [DW-1:0]  chk_exp,
    input  logic [AW-1:0]  chk_addr,
    input  logic [BGW-1:0] chk_bg,
    input  logic [DW-1:0]  rdata,
    output logic           fail,
    output logic [AW-1:0]  fail_addr,
    output logic [BGW-1:0] fail_bg
);
    logic           pend_v;
    logic [DW-1:0]  pend_exp;
    logic [AW-1:0]  pend_addr;
    logic [BGW-1:0] pend_bg;
    logic           mismatch;

    // one-cycle read latency: hold the expectation until data returns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_exp  <= '0;
            pend_addr <= '0;
            pend_bg   <= '0;
        end else begin
            pend_v    <= chk_en;
            pend_exp  <= chk_exp;
            pend_addr <= chk_addr;
            pend_bg   <= chk_bg;
        end
    end

    assign mismatch = pend_v && (rdata != pend_exp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_bg   <= '0;
        end else if (clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_bg   <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr;
            fail_bg   <= pend_bg;
        end
    end

    p_sticky_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> fail);

    p_first_fail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> ($stable(fail_addr) && $stable(fail_bg)));

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter  int AW   = 4,
    parameter  int DW   = 8,
    localparam int LOGW = $clog2(DW),
    localparam int NBG  = LOGW + 1,
    localparam int BGW  = (NBG > 1) ? $clog2(NBG) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_mode,
    input  logic           start,
    input  logic           alg_sel,
    input  logic [AW-1:0]  func_addr,
    input  logic [DW-1:0]  func_wdata,
    input  logic           func_we,
    input  logic [DW-1:0]  ram_rdata,
    output logic [AW-1:0]  ram_addr,
    output logic [DW-1:0]  ram_wdata,
    output logic           ram_we,
    output logic           busy,
    output logic           done,
    output logic           fail,
    output logic [AW-1:0]  fail_addr,
    output logic [BGW-1:0] fail_bg
);
    localparam logic [BGW-1:0] LAST_BG = BGW'(NBG - 1);

    mb_state_e      state, state_d;
    logic           alg_q;
    logic [2:0]     elem, elem_d;
    logic [1:0]     opi, opi_d;
    logic [BGW-1:0] bg, bg_d;

    logic           start_acc;
    logic           a_load, a_load_dn, a_step, cur_down, at_end;
    logic [AW-1:0]  seq_addr;
    logic [DW-1:0]  seq_wdata, bg_w;
    logic           last_op, last_elem, last_bg;
    logic           chk_en;
    mb_op_t         cur_op;

    function automatic logic [DW-1:0] bg_word(input logic [BGW-1:0] k);
        logic [DW-1:0] w;
        w = '0;
        if (k != '0)
            for (int i = 0; i < DW; i++)
                w[i] = (((i >> (LOGW - int'(k))) & 1) == 0);
        return w;
    endfunction

    assign start_acc = (state == ST_IDLE) && start && test_mode;
    assign cur_op    = elem_op(alg_q, elem, opi);
    assign cur_down  = elem_is_down(alg_q, elem);
    assign last_op   = (opi == elem_ops(alg_q, elem) - 2'd1);
    assign last_elem = (elem == prog_elems(alg_q) - 3'd1);
    assign last_bg   = (bg == LAST_BG);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // next state and sequencing
    always_comb begin
        state_d   = state;
        elem_d    = elem;
        opi_d     = opi;
        bg_d      = bg;
        a_load    = 1'b0;
        a_load_dn = 1'b0;
        a_step    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_acc) begin       // IDLE -> RUN
                    state_d = ST_RUN;
                    elem_d  = '0;
                    opi_d   = '0;
                    bg_d    = '0;
                    a_load  = 1'b1;
                end
            end
            ST_RUN: begin
                if (!last_op) begin
                    opi_d = opi + 2'd1;
                end else begin
                    opi_d = '0;
                    if (!at_end) begin
                        a_step = 1'b1;
                    end else if (!last_elem) begin
                        elem_d    = elem + 3'd1;
                        a_load    = 1'b1;
                        a_load_dn = elem_is_down(alg_q, elem + 3'd1);
                    end else if (!last_bg) begin
                        bg_d   = bg + 1'b1;
                        elem_d = '0;
                        a_load = 1'b1;
                    end else begin
                        state_d = ST_DRAIN;   // RUN -> DRAIN
                    end
                end
            end
            ST_DRAIN: state_d = ST_IDLE;      // DRAIN -> IDLE
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alg_q <= 1'b0;
            elem  <= '0;
            opi   <= '0;
            bg    <= '0;
            done  <= 1'b0;
        end else begin
            elem <= elem_d;
            opi  <= opi_d;
            bg   <= bg_d;
            if (start_acc) begin
                alg_q <= alg_sel;
                done  <= 1'b0;
            end else if (state == ST_DRAIN) begin
                done  <= 1'b1;
            end
        end
    end

    mbist_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (a_load),
        .load_down (a_load_dn),
        .step      (a_step),
        .cur_down  (cur_down),
        .addr      (seq_addr),
        .at_end    (at_end)
    );

    mbist_cmp #(.AW(AW), .DW(DW), .BGW(BGW)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_acc),
        .chk_en    (chk_en),
        .chk_exp   (seq_wdata),
        .chk_addr  (seq_addr),
        .chk_bg    (bg),
        .rdata     (ram_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_bg   (fail_bg)
    );

    // outputs
    always_comb begin
        bg_w      = bg_word(bg);
        seq_wdata = cur_op.val ? ~bg_w : bg_w;
        chk_en    = (state == ST_RUN) && cur_op.rd;
        busy      = (state != ST_IDLE);
        if (test_mode) begin
            ram_addr  = seq_addr;
            ram_wdata = seq_wdata;
            ram_we    = (state == ST_RUN) && !cur_op.rd;
        end else begin
            ram_addr  = func_addr;
            ram_wdata = func_wdata;
            ram_we    = func_we;
        end
    end

    p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (busy && !done && !fail));

    p_drain_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> (done && !busy));

    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_acc) |=> done);

endmodule

// File: tb/mbist_ctrl_bench.sv
module mbist_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int N   = 1 << AW;
    localparam int NBG = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0, start = 1'b0, alg_sel = 1'b0;
    logic [AW-1:0] func_addr = '0;
    logic [DW-1:0] func_wdata = '0;
    logic          func_we = 1'b0;
    logic [DW-1:0] ram_rdata;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          ram_we, busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [1:0]    fail_bg;

    int n_checks = 0, n_fail = 0;
    int fkind = 0;   // 0 none, 1 bit0/bit1 wired-AND at word 3, 2 bit2 stuck-at-1 at word 9

    always #(CLK_PERIOD/2) clk = ~clk;

    mbist_ctrl #(.AW(AW), .DW(DW)) u_mbist_ctrl (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
        .alg_sel(alg_sel), .func_addr(func_addr), .func_wdata(func_wdata),
        .func_we(func_we), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_bg(fail_bg)
    );

    function automatic logic [DW-1:0] faulty(int a, logic [DW-1:0] d);
        logic [DW-1:0] r = d;
        if (fkind == 1 && a == 3) r[0] = d[0] & d[1];
        if (fkind == 2 && a == 9) r[2] = 1'b1;
        return r;
    endfunction

    // RAM with one-cycle read latency
    logic [DW-1:0] mem [N];
    initial for (int i = 0; i < N; i++) mem[i] = '0;
    always @(posedge clk) begin
        ram_rdata <= mem[ram_addr];
        if (ram_we) mem[ram_addr] <= faulty(int'(ram_addr), ram_wdata);
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] bgp(int k);
        logic [DW-1:0] w = '0;
        if (k > 0) begin
            int blk = DW >> k;
            for (int i = 0; i < DW; i++) w[i] = ((i % (2*blk)) < blk);
        end
        return w;
    endfunction

    // reference model: expected operation stream and first mismatch
    typedef struct { int addr; bit we; logic [DW-1:0] wd; } op_t;
    op_t q[$];
    logic [DW-1:0] mm [N];
    int fm, fa, fb;

    task automatic add_elem(bit down, string ops, int k);
        for (int s = 0; s < N; s++) begin
            int a = down ? N-1-s : s;
            for (int c = 0; c < ops.len()/2; c++) begin
                logic [DW-1:0] d = (ops[2*c+1] == "1") ? ~bgp(k) : bgp(k);
                op_t o;
                o.addr = a;
                if (ops[2*c] == "w") begin
                    o.we = 1'b1; o.wd = d;
                    q.push_back(o);
                    mm[a] = faulty(a, d);
                end else begin
                    o.we = 1'b0; o.wd = '0;
                    q.push_back(o);
                    if (mm[a] != d && fm < 0) begin
                        fm = q.size() - 1; fa = a; fb = k;
                    end
                end
            end
        end
    endtask

    task automatic build(bit alg);
        q.delete();
        fm = -1; fa = 0; fb = 0;
        for (int i = 0; i < N; i++) mm[i] = '0;
        for (int k = 0; k < NBG; k++) begin
            if (!alg) begin
                add_elem(0, "w0", k); add_elem(0, "r0w1", k); add_elem(1, "r1w0r0", k);
            end else begin
                add_elem(0, "w0", k);   add_elem(0, "r0w1", k); add_elem(0, "r1w0", k);
                add_elem(1, "r0w1", k); add_elem(1, "r1w0", k); add_elem(0, "r0", k);
            end
        end
    endtask

    task automatic run(bit alg, int kind);
        string rq = alg ? "R5 R7" : "R4 R7";
        fkind = kind;
        build(alg);
        @(negedge clk);
        alg_sel = alg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < q.size(); j++) begin
            longint act = {ram_addr, ram_we, ram_we ? ram_wdata : 8'h00};
            longint exp = {q[j].addr[AW-1:0], q[j].we, q[j].wd};
            bit efail = (fm >= 0) && (j >= fm + 2);
            chk(act == exp, rq, act, exp);
            chk(busy && !done, "R3", {busy, done}, 2'b10);
            chk(fail == efail, "R8 R9", fail, efail);
            if (j == 7) start = 1'b1;     // ignored while running (R3)
            if (j == 8) start = 1'b0;
            @(negedge clk);
        end
        chk(busy && !ram_we, "R11 drain", {busy, ram_we}, 2'b10);
        @(negedge clk);
        chk(!busy && done, "R11 done", {busy, done}, 2'b01);
        chk(fail == (fm >= 0), "R9 final", fail, fm >= 0);
        if (fm >= 0) begin
            chk(fail_addr == fa, "R10 addr", fail_addr, fa);
            chk(fail_bg == fb, "R6 R10 bg", fail_bg, fb);
        end
        repeat (3) @(negedge clk);
        chk(done && !busy, "R11 hold", {busy, done}, 2'b01);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        func_addr = 4'h6; func_wdata = 8'h5A; func_we = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !fail, "R1 flags", {busy, done, fail}, 0);
        chk(fail_addr == 0 && fail_bg == 0, "R1 capture", {fail_addr, fail_bg}, 0);
        chk(ram_addr == 4'h6 && ram_wdata == 8'h5A && ram_we, "R1 mux",
            {ram_addr, ram_wdata, ram_we}, {4'h6, 8'h5A, 1'b1});
        // R2 functional path and start ignored
        func_addr = 4'hC; func_wdata = 8'hC3; func_we = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ram_addr == 4'hC && ram_wdata == 8'hC3 && !ram_we, "R2 mux",
            {ram_addr, ram_wdata, ram_we}, {4'hC, 8'hC3, 1'b0});
        @(negedge clk);
        chk(!busy, "R2 start ignored", busy, 0);
        func_we = 1'b0;
        test_mode = 1'b1;
        run(1'b0, 0);   // six-op program, clean
        run(1'b1, 0);   // March C-, clean
        run(1'b1, 1);   // bridge seen only on alternating background
        run(1'b0, 2);   // stuck bit, many mismatches
        run(1'b0, 0);   // fail cleared by new start
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule